// File: doc/BRIEF.md
# Accumulator-Link Operate Microinstruction Unit

This unit carries out the register-only family of operate microinstructions for a machine with a 12-bit accumulator and a single link bit. One instruction word can select any mix of eight micro-operations: clearing, complementing, incrementing, rotating, and exchanging halves. The unit applies all selected micro-operations within one instruction, in a fixed order of precedence. When the valid strobe is high and the word belongs to the family, the result is written into the accumulator and link registers on the clock edge.

The unit also produces four combinational flags that report whether the present word reads or writes the accumulator and the link. A pipeline can use them to detect hazards. A word outside the family is flagged as not handled. Such a word raises no flags and does not change the registers. Memory access, I/O, skips and program-counter updates belong to other blocks.

Top module: `acl_op_unit`

## Requirements
- R1: `handled_o` is 1 exactly when word bit 8 is 0. When bit 8 is 1, all four read/write flags are 0, and a valid strobe leaves `acc_o` and `link_o` unchanged.
- R2: The micro-operation selects are: bit 7 clears the accumulator, bit 6 clears the link, bit 5 complements the accumulator, and bit 4 complements the link. A clear takes effect before a complement of the same register, so clear together with complement gives all ones.
- R3: Bit 0 adds 1 to the accumulator, modulo 2^12. It acts after the clears and complements. If the sum wraps to zero, the link is inverted.
- R4: Bit 3 alone rotates the 13-bit value {link, acc} right by one, so acc bit 0 goes to the link and the link goes to acc bit 11. Bit 2 alone rotates it left by one. Rotation acts after the increment.
- R5: Bit 1 together with exactly one rotate bit performs that rotation twice.
- R6: Bit 1 with neither rotate bit exchanges acc bits 11:6 with bits 5:0 and leaves the link as it was after the earlier steps.
- R7: When bits 3 and 2 are both set, no rotation and no exchange happens, whatever bit 1 holds.
- R8: `rd_acc_o` is 1 when the word selects any of accumulator complement, either rotate, bit 1, or increment. `rd_link_o` is 1 when it selects any of link complement, either rotate, or increment.
- R9: `wr_acc_o` is `rd_acc_o` OR accumulator clear. `wr_link_o` is 1 when the word selects any of link clear, link complement, either rotate, or increment.
- R10: While `valid_i` is 0, `acc_o` and `link_o` keep their values.
- R11: A synchronous active-high `rst` sets `acc_o` and `link_o` to 0 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction strobe |
| instr_i | input | 12 | Instruction word |
| acc_i | input | 12 | Current accumulator |
| link_i | input | 1 | Current link |
| acc_o | output | 12 | Registered accumulator result |
| link_o | output | 1 | Registered link result |
| handled_o | output | 1 | Word belongs to the operate family |
| rd_acc_o | output | 1 | Word reads the accumulator |
| rd_link_o | output | 1 | Word reads the link |
| wr_acc_o | output | 1 | Word writes the accumulator |
| wr_link_o | output | 1 | Word writes the link |

## Verification
The bench targets the ordering corners.
- Clear plus complement must give all ones. A design that complements first would return zero.
- Complement plus increment on zero must flip the link through the wrap. A design with increment ahead of complement would leave the link alone.
- An increment followed by a left rotate catches a design that rotates the pre-increment value.
- Double rotates through the link and the both-rotates case catch a swap bit that is misread as an exchange, or rotation that is not suppressed.
- Unhandled words and an idle strobe must leave the registers intact. A design that ignores the group bit or the strobe would overwrite them.

// File: rtl/acl_op_pkg.sv
package acl_op_pkg;
   localparam int INSN_W  = 12;
   localparam int GRP_BIT = 8;
   localparam int UOP_W   = 8;

   // Field order mirrors word bits 7..0, so the low byte casts directly.
   typedef struct packed {
      logic clr_a;
      logic clr_l;
      logic inv_a;
      logic inv_l;
      logic rot_r;
      logic rot_l;
      logic swp;
      logic inc;
   } uop_t;
endpackage

// File: rtl/acl_op_decode.sv
module acl_op_decode
   import acl_op_pkg::*;
(
   input  logic [INSN_W-1:0] instr_i,
   output uop_t              uop_o,
   output logic              handled_o,
   output logic              rd_acc_o,
   output logic              rd_link_o,
   output logic              wr_acc_o,
   output logic              wr_link_o
);
   logic any_rot;

   assign handled_o = ~instr_i[GRP_BIT];
   assign uop_o     = handled_o ? uop_t'(instr_i[UOP_W-1:0]) : '0;
   assign any_rot   = uop_o.rot_r | uop_o.rot_l;

   assign rd_acc_o  = uop_o.inv_a | any_rot | uop_o.swp | uop_o.inc;
   assign rd_link_o = uop_o.inv_l | any_rot | uop_o.inc;
   assign wr_acc_o  = uop_o.clr_a | uop_o.inv_a | any_rot | uop_o.swp | uop_o.inc;
   assign wr_link_o = uop_o.clr_l | uop_o.inv_l | any_rot | uop_o.inc;
endmodule

// File: rtl/acl_op_datapath.sv
module acl_op_datapath
   import acl_op_pkg::*;
#(
   parameter int DATA_W = 12
)(
   input  uop_t              uop_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic              link_i,
   output logic [DATA_W-1:0] acc_o,
   output logic              link_o
);
   localparam int HALF_W     = DATA_W / 2;
   localparam int ROT_PASSES = 2;
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   generate
      if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("acl_op_datapath: DATA_W must be even and at least 2");
      end
   endgenerate

   // Step 1: clears, complements, increment.
   logic [DATA_W-1:0] a_pre;
   logic              l_pre;

   always_comb begin
      a_pre = acc_i;
      l_pre = link_i;
      if (uop_i.clr_a) a_pre = '0;
      if (uop_i.clr_l) l_pre = 1'b0;
      if (uop_i.inv_a) a_pre = ~a_pre;
      if (uop_i.inv_l) l_pre = ~l_pre;
      if (uop_i.inc) begin
         a_pre = a_pre + ONE;
         if (a_pre == '0) l_pre = ~l_pre;
      end
   end

   // Step 2: chained single-bit rotation passes through {link, acc}.
   logic                           rot_one;
   logic                           dir_r;
   logic [ROT_PASSES:0][DATA_W-1:0] ra;
   logic [ROT_PASSES:0]             rl;

   assign rot_one = uop_i.rot_r ^ uop_i.rot_l;
   assign dir_r   = uop_i.rot_r;
   assign ra[0]   = a_pre;
   assign rl[0]   = l_pre;

   generate
      for (genvar p = 0; p < ROT_PASSES; p++) begin : g_pass
         logic en;
         if (p == 0) begin : g_first
            assign en = rot_one;
         end else begin : g_extra
            assign en = rot_one & uop_i.swp;
         end
         assign rl[p+1] = !en ? rl[p] : (dir_r ? ra[p][0] : ra[p][DATA_W-1]);
         assign ra[p+1] = !en ? ra[p]
                        : (dir_r ? {rl[p], ra[p][DATA_W-1:1]}
                                 : {ra[p][DATA_W-2:0], rl[p]});
      end
   endgenerate

   // Step 3: half exchange when the modifier stands alone.
   logic swap_only;
   assign swap_only = uop_i.swp & ~uop_i.rot_r & ~uop_i.rot_l;

   assign acc_o  = swap_only ? {ra[ROT_PASSES][HALF_W-1:0], ra[ROT_PASSES][DATA_W-1:HALF_W]}
                             : ra[ROT_PASSES];
   assign link_o = rl[ROT_PASSES];
endmodule

// File: rtl/acl_op_unit.sv
module acl_op_unit
   import acl_op_pkg::*;
#(
   parameter int DATA_W = 12
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              valid_i,
   input  logic [INSN_W-1:0] instr_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic              link_i,
   output logic [DATA_W-1:0] acc_o,
   output logic              link_o,
   output logic              handled_o,
   output logic              rd_acc_o,
   output logic              rd_link_o,
   output logic              wr_acc_o,
   output logic              wr_link_o
);
   uop_t              uop;
   logic [DATA_W-1:0] acc_nxt;
   logic              link_nxt;

   acl_op_decode u_dec (
      .instr_i   (instr_i),
      .uop_o     (uop),
      .handled_o (handled_o),
      .rd_acc_o  (rd_acc_o),
      .rd_link_o (rd_link_o),
      .wr_acc_o  (wr_acc_o),
      .wr_link_o (wr_link_o)
   );

   acl_op_datapath #(.DATA_W(DATA_W)) u_dp (
      .uop_i  (uop),
      .acc_i  (acc_i),
      .link_i (link_i),
      .acc_o  (acc_nxt),
      .link_o (link_nxt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_o  <= '0;
         link_o <= 1'b0;
      end else if (valid_i && handled_o) begin
         acc_o  <= acc_nxt;
         link_o <= link_nxt;
      end
   end
endmodule

// File: rtl/acl_op_unit_chk.sv
module acl_op_unit_chk
   import acl_op_pkg::*;
#(
   parameter int DATA_W = 12
)(
   input logic              clk,
   input logic              rst,
   input logic              valid_i,
   input logic [INSN_W-1:0] instr_i,
   input logic [DATA_W-1:0] acc_i,
   input logic              link_i,
   input logic [DATA_W-1:0] acc_o,
   input logic              link_o,
   input logic              handled_o,
   input logic              rd_acc_o,
   input logic              rd_link_o,
   input logic              wr_acc_o,
   input logic              wr_link_o
);
   localparam int HALF_W = DATA_W / 2;

   logic rst_q = 1'b0;
   always_ff @(posedge clk) rst_q <= rst;

   // R11: one edge after reset the registers read zero.
   always @(posedge clk) begin
      if (rst_q) a_r11_reset_clears : assert (acc_o == '0 && link_o == 1'b0);
   end

   // R9: a register that is read is also written.
   always_comb begin
      a_r9_write_covers_read : assert (!(rd_acc_o && !wr_acc_o) && !(rd_link_o && !wr_link_o));
   end

   a_r1_flags_quiet : assert property (@(posedge clk) disable iff (rst)
      !handled_o |-> !(rd_acc_o || rd_link_o || wr_acc_o || wr_link_o));

   a_r1_unhandled_holds : assert property (@(posedge clk) disable iff (rst)
      (valid_i && !handled_o) |=> ($stable(acc_o) && $stable(link_o)));

   a_r10_idle_holds : assert property (@(posedge clk) disable iff (rst)
      !valid_i |=> ($stable(acc_o) && $stable(link_o)));

   a_r6_swap_only : assert property (@(posedge clk) disable iff (rst)
      (valid_i && !instr_i[8] && instr_i[7:0] == 8'b0000_0010)
      |=> (acc_o == {$past(acc_i[HALF_W-1:0]), $past(acc_i[DATA_W-1:HALF_W])}
           && link_o == $past(link_i)));

   a_r2_clear_pair : assert property (@(posedge clk) disable iff (rst)
      (valid_i && !instr_i[8] && instr_i[7:0] == 8'b1100_0000)
      |=> (acc_o == '0 && link_o == 1'b0));
endmodule

bind acl_op_unit acl_op_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .valid_i   (valid_i),
   .instr_i   (instr_i),
   .acc_i     (acc_i),
   .link_i    (link_i),
   .acc_o     (acc_o),
   .link_o    (link_o),
   .handled_o (handled_o),
   .rd_acc_o  (rd_acc_o),
   .rd_link_o (rd_link_o),
   .wr_acc_o  (wr_acc_o),
   .wr_link_o (wr_link_o)
);

// File: tb/sim_acl_op_unit.sv
`timescale 1ns/1ps
module sim_acl_op_unit;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        valid_i = 1'b0;
   logic [11:0] instr_i = '0;
   logic [11:0] acc_i = '0;
   logic        link_i = 1'b0;
   logic [11:0] acc_o;
   logic        link_o, handled_o, rd_acc_o, rd_link_o, wr_acc_o, wr_link_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   acl_op_unit u0 (
      .clk(clk), .rst(rst), .valid_i(valid_i), .instr_i(instr_i),
      .acc_i(acc_i), .link_i(link_i), .acc_o(acc_o), .link_o(link_o),
      .handled_o(handled_o), .rd_acc_o(rd_acc_o), .rd_link_o(rd_link_o),
      .wr_acc_o(wr_acc_o), .wr_link_o(wr_link_o)
   );

   task automatic chk(input string req, input logic [12:0] act, input logic [12:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%o expected=%o", req, act, exp);
      end
   endtask

   // Apply one valid word, then check the registered {link, acc}.
   task automatic run_op(input string req, input logic [11:0] w, input logic [11:0] a,
                         input logic l, input logic [11:0] ea, input logic el);
      @(negedge clk);
      instr_i = w; acc_i = a; link_i = l; valid_i = 1'b1;
      @(negedge clk);
      valid_i = 1'b0;
      chk(req, {link_o, acc_o}, {el, ea});
   endtask

   task automatic flag_chk(input string req, input logic [11:0] w, input logic [4:0] exp);
      @(negedge clk);
      instr_i = w; valid_i = 1'b0;
      #1;
      chk(req, {8'd0, handled_o, rd_acc_o, rd_link_o, wr_acc_o, wr_link_o}, {8'd0, exp});
   endtask

   task automatic t_reset;
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      chk("R11 reset", {link_o, acc_o}, 13'o0);
   endtask

   task automatic t_clear_complement;
      run_op("R2 clear both",         12'o0300, 12'o5555, 1'b1, 12'o0000, 1'b0);
      run_op("R2 complement acc",     12'o0040, 12'o1234, 1'b1, 12'o6543, 1'b1);
      run_op("R2 complement link",    12'o0020, 12'o1234, 1'b0, 12'o1234, 1'b1);
      run_op("R2 clear then cmp acc", 12'o0240, 12'o1234, 1'b0, 12'o7777, 1'b0);
      run_op("R2 clear then cmp lnk", 12'o0120, 12'o0000, 1'b0, 12'o0000, 1'b1);
   endtask

   task automatic t_increment;
      run_op("R3 inc no wrap",        12'o0001, 12'o7776, 1'b0, 12'o7777, 1'b0);
      run_op("R3 inc wrap flips lnk", 12'o0001, 12'o7777, 1'b1, 12'o0000, 1'b0);
      run_op("R3 cmp then inc",       12'o0041, 12'o0000, 1'b0, 12'o0000, 1'b1);
      run_op("R3 clear then inc",     12'o0201, 12'o4321, 1'b0, 12'o0001, 1'b0);
      run_op("R3 inc then rot left",  12'o0005, 12'o7777, 1'b0, 12'o0001, 1'b0);
   endtask

   task automatic t_rotate;
      run_op("R4 rot right",          12'o0010, 12'o0001, 1'b0, 12'o0000, 1'b1);
      run_op("R4 rot right link in",  12'o0010, 12'o6000, 1'b1, 12'o7000, 1'b0);
      run_op("R4 rot left",           12'o0004, 12'o4000, 1'b0, 12'o0000, 1'b1);
      run_op("R5 double right",       12'o0012, 12'o0003, 1'b0, 12'o4000, 1'b1);
      run_op("R5 double left",        12'o0006, 12'o4001, 1'b0, 12'o0005, 1'b0);
   endtask

   task automatic t_swap_and_both;
      run_op("R6 swap halves",        12'o0002, 12'o1234, 1'b1, 12'o3412, 1'b1);
      run_op("R6 swap after clr lnk", 12'o0102, 12'o7700, 1'b1, 12'o0077, 1'b0);
      run_op("R7 both rotates",       12'o0014, 12'o1234, 1'b1, 12'o1234, 1'b1);
      run_op("R7 both rotates+swap",  12'o0016, 12'o1234, 1'b0, 12'o1234, 1'b0);
   endtask

   task automatic t_unhandled_and_idle;
      run_op("R1 setup",              12'o0040, 12'o0000, 1'b1, 12'o7777, 1'b1);
      run_op("R1 unhandled holds",    12'o0700, 12'o0123, 1'b0, 12'o7777, 1'b1);
      run_op("R1 unhandled holds 2",  12'o7401, 12'o0000, 1'b0, 12'o7777, 1'b1);
      @(negedge clk);
      instr_i = 12'o0200; acc_i = 12'o0055; link_i = 1'b0; valid_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R10 idle holds", {link_o, acc_o}, {1'b1, 12'o7777});
   endtask

   // Flag order: {handled, rd_acc, rd_link, wr_acc, wr_link}
   task automatic t_flags;
      flag_chk("R8 R9 flags clr acc",  12'o0200, 5'b10010);
      flag_chk("R8 R9 flags clr link", 12'o0100, 5'b10001);
      flag_chk("R8 R9 flags swap",     12'o0002, 5'b11010);
      flag_chk("R8 R9 flags rot",      12'o0010, 5'b11111);
      flag_chk("R8 R9 flags cmp link", 12'o0020, 5'b10101);
      flag_chk("R8 R9 flags inc",      12'o0001, 5'b11111);
      flag_chk("R8 R9 flags none",     12'o0000, 5'b10000);
      flag_chk("R1 flags unhandled",   12'o0777 | 12'o0400, 5'b00000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_clear_complement();
      t_increment();
      t_rotate();
      t_swap_and_both();
      t_unhandled_and_idle();
      t_flags();
      t_reset();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R10 watchdog actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule